// File: doc/BRIEF.md
# Ring Oscillator Frequency Meter

The meter times an on-chip ring oscillator against the reference clock that runs the register interface. Software sets a window length in oscillator cycles, turns on the free-running measurement clock gate, and sets the meter enable. The meter then counts reference cycles for as long as the oscillator takes to complete the window. When the window ends, the count is stored in a result register and a valid status bit rises. Software derives the oscillator frequency from the ratio of the window to the result.

Start and finish cross between the two clock domains as levels, each through a two-flop synchroniser. The result therefore includes a small fixed overhead: at most four oscillator periods plus a few reference periods. A window of zero is defined as a failed detection. It completes at once with a result of zero, so software always receives a value it can test.

Top module: `ring_osc_freq_meter`

## Requirements
- R1: After reset, the window field reads 1024, both enables read 0, valid reads 0 and the result reads 0.
- R2: Register map by word address. Address 0 holds the window in bits 23:0 and the meter enable in bit 24. Address 1 holds the free-run enable in bit 8 and valid in bit 0; valid is read-only. Address 2 holds the result, zero-extended. Address 3 reads zero.
- R3: No measurement runs unless the meter enable and the free-run enable are both set. With either one clear, valid stays 0 and the result stays 0.
- R4: When both enables are set and the window is W>0, valid rises. The result R then satisfies W*Tosc/Tref - 1 <= R <= (W+4)*Tosc/Tref + 6.
- R5: Once valid is set, it stays set and the result stays unchanged for as long as the meter enable remains set.
- R6: Clearing the meter enable clears valid and the result. A later measurement starts both counters from zero.
- R7: A write to the window field is ignored while the meter enable is set. The enable bit in the same write still takes effect.
- R8: A window of zero sets valid with a result of zero, the code for a failed detection.
- R9: The reference counter saturates at all ones of RESULT_W bits instead of wrapping.
- R10: Clearing the free-run enable during a measurement aborts it. Setting the free-run enable again starts a fresh measurement from zero counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock, also clocks the register interface |
| oscClk | input | 1 | Ring oscillator clock under measurement |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr, combinational |

## Verification
If the measurement state machine sticks, valid never rises. That shows at the status bit within one window time plus the handshake overhead. A counter that is not cleared or that wraps gives a result outside the band of R4 on the very next measurement, so the bench sweeps several oscillator periods and window lengths and checks each result against an arithmetic band. Errors in the sticky valid or in the clear path show on the status register within two reference cycles of the enable write that should cause them.

// File: rtl/rofm_pkg.sv
package rofm_pkg;
  localparam int REG_W     = 32;
  localparam int WIN_W     = 24;
  localparam int EN_BIT    = 24;
  localparam int FRUN_BIT  = 8;
  localparam int VALID_BIT = 0;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MON  = 2'd1;
  localparam logic [1:0] ADDR_RES  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } measState_t;

  // strobes from control to datapath, all in the reference domain
  typedef struct packed {
    logic clear;        // zero reference counter and result
    logic count;        // advance reference counter
    logic capture;      // load result from reference counter
    logic captureZero;  // load result with the failure code
  } dpCmd_t;
endpackage

// File: rtl/rofm_sync.sv
module rofm_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      dOut <= '0;
    end else begin
      meta <= dIn;
      dOut <= meta;
    end
  end
endmodule

// File: rtl/rofm_ctrl.sv
module rofm_ctrl
  import rofm_pkg::*;
#(
  parameter int RESULT_W       = 32,
  parameter int DEFAULT_WINDOW = 1024
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  input  logic                doneSeen,
  input  logic [RESULT_W-1:0] resultVal,
  output logic                meterEn,
  output logic                freeRunEn,
  output logic [WIN_W-1:0]    window,
  output logic                valid,
  output logic                startReq,
  output dpCmd_t              cmd
);
  measState_t state, stateNext;
  logic armed;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[REG_W-1:EN_BIT+1];

  // register writes; the window is frozen while the meter is enabled
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      window    <= WIN_W'(DEFAULT_WINDOW);
      meterEn   <= 1'b0;
      freeRunEn <= 1'b0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_CTRL: begin
          if (!meterEn) window <= regWdata[WIN_W-1:0];
          meterEn <= regWdata[EN_BIT];
        end
        ADDR_MON: freeRunEn <= regWdata[FRUN_BIT];
        default: ;
      endcase
    end
  end

  assign armed = meterEn && freeRunEn;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    case (state)
      ST_IDLE: begin
        if (armed && !doneSeen) begin
          if (window == '0) begin
            cmd.captureZero = 1'b1;
            stateNext       = ST_DONE;
          end else begin
            cmd.clear = 1'b1;
            stateNext = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (!armed) begin
          cmd.clear = 1'b1;
          stateNext = ST_IDLE;
        end else if (doneSeen) begin
          cmd.capture = 1'b1;
          stateNext   = ST_DONE;
        end else begin
          cmd.count = 1'b1;
        end
      end
      ST_DONE: begin
        if (!meterEn) begin
          cmd.clear = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign valid    = (state == ST_DONE);
  assign startReq = (state == ST_RUN);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[WIN_W-1:0] = window;
        regRdata[EN_BIT]    = meterEn;
      end
      ADDR_MON: begin
        regRdata[FRUN_BIT]  = freeRunEn;
        regRdata[VALID_BIT] = valid;
      end
      ADDR_RES: regRdata = REG_W'(resultVal);
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/rofm_datapath.sv
module rofm_datapath
  import rofm_pkg::*;
#(
  parameter int RESULT_W = 32
) (
  input  logic                refClk,
  input  logic                oscClk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic                startReq,
  input  logic [WIN_W-1:0]    window,
  output logic                doneSeen,
  output logic [RESULT_W-1:0] refCount,
  output logic [RESULT_W-1:0] resultVal
);
  localparam logic [RESULT_W-1:0] CNT_MAX = '1;

  logic             startOsc;
  logic [WIN_W-1:0] oscCount;
  logic             oscDone;

  // reference-domain counter and result
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      refCount  <= '0;
      resultVal <= '0;
    end else begin
      if (cmd.clear)
        refCount <= '0;
      else if (cmd.count && refCount != CNT_MAX)
        refCount <= refCount + 1'b1;

      if (cmd.clear || cmd.captureZero)
        resultVal <= '0;
      else if (cmd.capture)
        resultVal <= refCount;
    end
  end

  rofm_sync #(.WIDTH(1)) u_startSync (
    .clk  (oscClk),
    .rstN (rstN),
    .dIn  (startReq),
    .dOut (startOsc)
  );

  // oscillator-domain window counter; window is quasi-static while running
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      oscCount <= '0;
      oscDone  <= 1'b0;
    end else if (!startOsc) begin
      oscCount <= '0;
      oscDone  <= 1'b0;
    end else if (!oscDone) begin
      oscCount <= oscCount + 1'b1;
      if (oscCount + 1'b1 == window) oscDone <= 1'b1;
    end
  end

  rofm_sync #(.WIDTH(1)) u_doneSync (
    .clk  (refClk),
    .rstN (rstN),
    .dIn  (oscDone),
    .dOut (doneSeen)
  );
endmodule

// File: rtl/ring_osc_freq_meter.sv
module ring_osc_freq_meter
  import rofm_pkg::*;
#(
  parameter int RESULT_W       = 32,
  parameter int DEFAULT_WINDOW = 1024
) (
  input  logic        refClk,
  input  logic        oscClk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata
);
  dpCmd_t              cmd;
  logic                meterEn;
  logic                freeRunEn;
  logic [WIN_W-1:0]    window;
  logic                valid;
  logic                startReq;
  logic                doneSeen;
  logic [RESULT_W-1:0] refCount;
  logic [RESULT_W-1:0] resultVal;

  rofm_ctrl #(
    .RESULT_W       (RESULT_W),
    .DEFAULT_WINDOW (DEFAULT_WINDOW)
  ) u_ctrl (
    .refClk    (refClk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .doneSeen  (doneSeen),
    .resultVal (resultVal),
    .meterEn   (meterEn),
    .freeRunEn (freeRunEn),
    .window    (window),
    .valid     (valid),
    .startReq  (startReq),
    .cmd       (cmd)
  );

  rofm_datapath #(
    .RESULT_W (RESULT_W)
  ) u_dp (
    .refClk    (refClk),
    .oscClk    (oscClk),
    .rstN      (rstN),
    .cmd       (cmd),
    .startReq  (startReq),
    .window    (window),
    .doneSeen  (doneSeen),
    .refCount  (refCount),
    .resultVal (resultVal)
  );
endmodule

// File: rtl/ring_osc_freq_meter_chk.sv
module ring_osc_freq_meter_chk #(
  parameter int RESULT_W = 32
) (
  input logic                refClk,
  input logic                rstN,
  input logic                meterEn,
  input logic                freeRunEn,
  input logic                valid,
  input logic [23:0]         window,
  input logic [RESULT_W-1:0] result,
  input logic [RESULT_W-1:0] refCount
);
  localparam logic [RESULT_W-1:0] CNT_MAX = '1;

  a_r3_count_needs_arm: assert property (@(posedge refClk) disable iff (!rstN)
    (!$stable(refCount) && refCount != '0) |-> $past(meterEn && freeRunEn));

  a_r5_valid_holds: assert property (@(posedge refClk) disable iff (!rstN)
    (valid && meterEn) |=> valid);

  a_r5_result_stable: assert property (@(posedge refClk) disable iff (!rstN)
    (valid && meterEn) |=> $stable(result));

  a_r6_disable_clears_valid: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(meterEn) |=> !valid);

  a_r7_window_frozen: assert property (@(posedge refClk) disable iff (!rstN)
    (meterEn && $past(meterEn)) |-> $stable(window));

  a_r8_zero_window_result: assert property (@(posedge refClk) disable iff (!rstN)
    ($rose(valid) && window == '0) |-> result == '0);

  a_r9_no_overflow: assert property (@(posedge refClk) disable iff (!rstN)
    (refCount == CNT_MAX) |=> (refCount == CNT_MAX || refCount == '0));
endmodule

bind ring_osc_freq_meter ring_osc_freq_meter_chk #(.RESULT_W(RESULT_W)) u_chk (
  .refClk    (refClk),
  .rstN      (rstN),
  .meterEn   (meterEn),
  .freeRunEn (freeRunEn),
  .valid     (valid),
  .window    (window),
  .result    (resultVal),
  .refCount  (refCount)
);

// File: tb/ring_osc_freq_meter_tb.sv
module ring_osc_freq_meter_tb;
  localparam logic [31:0] EN   = 32'h0100_0000;
  localparam logic [31:0] FRUN = 32'h0000_0100;

  logic        refClk = 1'b0;
  logic        oscClk = 1'b0;
  logic        rstN   = 1'b0;
  logic        regWe  = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdata, rdataSat;
  int          oscHalf = 4;
  int          nChecks = 0;
  int          nFail   = 0;

  always #5 refClk = ~refClk;
  always begin
    #(oscHalf) oscClk = ~oscClk;
  end

  ring_osc_freq_meter u_dut (
    .refClk(refClk), .oscClk(oscClk), .rstN(rstN), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdata)
  );

  ring_osc_freq_meter #(.RESULT_W(8)) u_dutSat (
    .refClk(refClk), .oscClk(oscClk), .rstN(rstN), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdataSat)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkBand(input string req, input longint act, input longint lo, input longint hi);
    nChecks++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge refClk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge refClk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d, output logic [31:0] dSat);
    @(negedge refClk);
    regAddr = a;
    #1;
    d = rdata;
    dSat = rdataSat;
  endtask

  task automatic waitValid(input int limit, output bit seen);
    logic [31:0] d, ds;
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      busRead(2'd1, d, ds);
      if (d[0]) seen = 1'b1;
    end
  endtask

  task automatic startMeas(input int w);
    busWrite(2'd0, 32'h0);
    busWrite(2'd0, EN | 32'(w));
  endtask

  function automatic longint loBound(input int w, input int per);
    return longint'(w) * per / 10 - 1;
  endfunction

  function automatic longint hiBound(input int w, input int per);
    return (longint'(w + 4) * per + 9) / 10 + 6;
  endfunction

  initial begin
    repeat (150000) @(posedge refClk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d, ds;
    bit seen;
    int halves [4] = '{4, 7, 11, 17};
    int wins   [4] = '{1, 5, 64, 1024};

    repeat (5) @(negedge refClk);
    rstN = 1'b1;

    // R1 reset state
    busRead(2'd0, d, ds);
    check(d == 32'h400, "R1 ctrl", d, 32'h400);
    busRead(2'd1, d, ds);
    check(d == 0, "R1 mon", d, 0);
    busRead(2'd2, d, ds);
    check(d == 0, "R1 result", d, 0);
    // R2 unused address
    busRead(2'd3, d, ds);
    check(d == 0, "R2 addr3", d, 0);

    // R3 meter enable without free-run
    busWrite(2'd0, EN | 32'd1024);
    repeat (3000) @(negedge refClk);
    busRead(2'd1, d, ds);
    check(d[0] == 1'b0, "R3 no valid w/o freerun", d[0], 0);
    busRead(2'd2, d, ds);
    check(d == 0, "R3 result w/o freerun", d, 0);
    // R3 free-run without meter enable; R2 valid bit read-only
    busWrite(2'd0, 32'd1024);
    busWrite(2'd1, FRUN | 32'h1);
    repeat (3000) @(negedge refClk);
    busRead(2'd1, d, ds);
    check(d == FRUN, "R2 R3 mon w/o meter enable", d, FRUN);

    // R4 sweep of oscillator periods and windows
    foreach (halves[p]) begin
      foreach (wins[k]) begin
        busWrite(2'd0, 32'h0);
        oscHalf = halves[p];
        repeat (4) @(negedge refClk);
        startMeas(wins[k]);
        waitValid(8000, seen);
        check(seen, "R4 valid rises", seen, 1);
        busRead(2'd2, d, ds);
        checkBand("R4 result band", d, loBound(wins[k], 2 * halves[p]),
                  hiBound(wins[k], 2 * halves[p]));
        if (halves[p] == 11 && wins[k] == 1024)
          check(ds == 32'd255, "R9 saturated result", ds, 255);
      end
    end

    // R5 valid sticky, result stable
    busRead(2'd2, d, ds);
    begin
      logic [31:0] held;
      held = d;
      repeat (300) @(negedge refClk);
      busRead(2'd1, d, ds);
      check(d[0] == 1'b1, "R5 valid sticky", d[0], 1);
      busRead(2'd2, d, ds);
      check(d == held, "R5 result held", d, held);
    end

    // R7 window write ignored while enabled
    busWrite(2'd0, EN | 32'd77);
    busRead(2'd0, d, ds);
    check(d == (EN | 32'd1024), "R7 window frozen", d, EN | 32'd1024);

    // R6 clear enable clears valid and result
    busWrite(2'd0, 32'h0);
    busRead(2'd1, d, ds);
    check(d[0] == 1'b0, "R6 valid cleared", d[0], 0);
    busRead(2'd2, d, ds);
    check(d == 0, "R6 result cleared", d, 0);
    startMeas(64);
    waitValid(8000, seen);
    busRead(2'd2, d, ds);
    checkBand("R6 fresh measurement", d, loBound(64, 34), hiBound(64, 34));

    // R8 zero window
    startMeas(0);
    waitValid(20, seen);
    check(seen, "R8 zero window valid", seen, 1);
    busRead(2'd2, d, ds);
    check(d == 0 && ds == 0, "R8 zero window result", d, 0);

    // R10 abort by free-run clear, then restart
    startMeas(1024);
    repeat (200) @(negedge refClk);
    busWrite(2'd1, 32'h0);
    repeat (4000) @(negedge refClk);
    busRead(2'd1, d, ds);
    check(d[0] == 1'b0, "R10 aborted no valid", d[0], 0);
    busWrite(2'd1, FRUN);
    waitValid(8000, seen);
    check(seen, "R10 restart valid", seen, 1);
    busRead(2'd2, d, ds);
    checkBand("R10 restart result", d, loBound(1024, 34), hiBound(1024, 34));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule